// File: doc/BRIEF.md
# Dual-Key Protected Register Bank

A bank of 32-bit control words behind a simple synchronous register port. Ordinary words can only be changed while two separate key flags are both set. Each flag is armed by writing a fixed unlock constant to its own key offset. A write to the primary key offset arms or clears both flags together. A write to the secondary key offset arms or clears only the secondary flag, so software can relock the bank by clearing that one flag.

Writes to ordinary words while the bank is locked are dropped, and so are writes whose word index lies past the implemented bank. Both cases raise a one-cycle error strobe. Reads are never gated by the lock. Each read returns its data one cycle after the request. The word index is the byte offset divided by four; the two low offset bits are ignored.

Top module: `prot_regbank`

## Requirements
- R1: After reset both key flags are 0, so the bank is locked. Each ordinary word i holds RST_BASE + i (default RST_BASE = 32'hA5A5_0000).
- R2: A write to byte offset 0x00 (primary key) sets both flags to 1 when the data equals UNLOCK_KEY (default 32'h1688A8A8), and sets both to 0 for any other data. This applies whether the bank is locked or not.
- R3: A write to byte offset 0x10 (secondary key) sets only the secondary flag, to 1 on a match and to 0 otherwise. The primary flag keeps its value.
- R4: A write to any other in-range offset is discarded when either flag is 0, and it raises err_o.
- R5: With both flags at 1, a write to an in-range ordinary word stores the full 32-bit data and does not raise err_o.
- R6: A write whose index (offset >> 2) is NUM_REGS or more changes no state and raises err_o, whatever the lock state.
- R7: rd_en_i returns data on rdata_o one cycle later. A key offset reads as its flag in bit 0 with zeros above. An ordinary word reads as its stored value in either lock state. An out-of-range index reads as 0.
- R8: err_o is high only in the cycle right after a rejected write, and low in every other cycle.
- R9: A key write stores a single match bit. Data that differs from UNLOCK_KEY in any bit clears the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Write request |
| rd_en_i | input | 1 | Read request |
| offset_i | input | ADDR_W | Byte offset |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, valid the cycle after rd_en_i |
| err_o | output | 1 | One-cycle pulse after a rejected write |

## Verification
On every cycle the assertions check the key update rules, that a locked or out-of-range write leads to the error pulse, that the error never appears without a write the cycle before, and that key reads return the flag. Only the bench scenarios can show that a word write is really dropped or stored: that needs a readback of the word after it was written. The same holds for relocking through the secondary key and for the near-miss key value, which shows that a single match bit is stored rather than the word.

// File: rtl/prb_pkg.sv
package prb_pkg;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned PRI_KEY_IDX = 0;  // byte offset 0x00
  localparam int unsigned SEC_KEY_IDX = 4;  // byte offset 0x10
  typedef logic [DATA_W-1:0] word_t;
endpackage

// File: rtl/prb_decode.sv
module prb_decode #(
  parameter int unsigned ADDR_W   = 8,
  parameter int unsigned NUM_REGS = 16,
  localparam int unsigned IDX_W   = ADDR_W - 2
) (
  input  logic [ADDR_W-1:0] offset_i,
  output logic [IDX_W-1:0]  idx_o,
  output logic              in_range_o,
  output logic              hit_pri_o,
  output logic              hit_sec_o
);
  assign idx_o      = offset_i[ADDR_W-1:2];
  assign in_range_o = 32'(idx_o) < NUM_REGS;
  assign hit_pri_o  = 32'(idx_o) == prb_pkg::PRI_KEY_IDX;
  assign hit_sec_o  = 32'(idx_o) == prb_pkg::SEC_KEY_IDX;
endmodule

// File: rtl/prb_keys.sv
module prb_keys (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic wr_pri_i,
  input  logic wr_sec_i,
  input  logic match_i,
  output logic pri_o,
  output logic sec_o,
  output logic unlocked_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pri_o <= 1'b0;
      sec_o <= 1'b0;
    end else if (wr_pri_i) begin
      pri_o <= match_i;
      sec_o <= match_i;
    end else if (wr_sec_i) begin
      sec_o <= match_i;
    end
  end

  assign unlocked_o = pri_o & sec_o;

  assert_pri_sets_both_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_pri_i |=> (pri_o == $past(match_i)) && (sec_o == $past(match_i)));
  assert_sec_only_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_sec_i && !wr_pri_i) |=> (sec_o == $past(match_i)) && $stable(pri_o));
  assert_flags_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_pri_i && !wr_sec_i) |=> $stable(pri_o) && $stable(sec_o));
endmodule

// File: rtl/prb_words.sv
module prb_words #(
  parameter int unsigned           NUM_REGS = 16,
  parameter int unsigned           IDX_W    = 6,
  parameter prb_pkg::word_t        RST_BASE = 32'hA5A5_0000
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 we_i,
  input  logic [IDX_W-1:0]     wr_idx_i,
  input  prb_pkg::word_t       wdata_i,
  input  logic [IDX_W-1:0]     rd_idx_i,
  output prb_pkg::word_t       rd_word_o
);
  prb_pkg::word_t mem [NUM_REGS];

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_word
    localparam prb_pkg::word_t RST_VAL = RST_BASE + prb_pkg::word_t'(i);
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                   mem[i] <= RST_VAL;
      else if (we_i && 32'(wr_idx_i) == i)           mem[i] <= wdata_i;
    end

    assert_word_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(we_i && 32'(wr_idx_i) == i) |=> $stable(mem[i]));
  end

  always_comb begin
    rd_word_o = '0;
    for (int i = 0; i < NUM_REGS; i++)
      if (32'(rd_idx_i) == i) rd_word_o = mem[i];
  end
endmodule

// File: rtl/prot_regbank.sv
module prot_regbank #(
  parameter int unsigned    ADDR_W     = 8,
  parameter int unsigned    NUM_REGS   = 16,
  parameter prb_pkg::word_t UNLOCK_KEY = 32'h1688A8A8,
  parameter prb_pkg::word_t RST_BASE   = 32'hA5A5_0000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] offset_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o,
  output logic              err_o
);
  localparam int unsigned IDX_W = ADDR_W - 2;

  logic [IDX_W-1:0] idx;
  logic in_range, hit_pri, hit_sec, hit_key;
  logic key_pri, key_sec, unlocked;
  logic word_we, err_d;
  prb_pkg::word_t rd_word;

  prb_decode #(.ADDR_W(ADDR_W), .NUM_REGS(NUM_REGS)) u_dec (
    .offset_i(offset_i), .idx_o(idx), .in_range_o(in_range),
    .hit_pri_o(hit_pri), .hit_sec_o(hit_sec)
  );

  assign hit_key = in_range & (hit_pri | hit_sec);

  prb_keys u_keys (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .wr_pri_i(wr_en_i & in_range & hit_pri),
    .wr_sec_i(wr_en_i & in_range & hit_sec),
    .match_i(wdata_i == UNLOCK_KEY),
    .pri_o(key_pri), .sec_o(key_sec), .unlocked_o(unlocked)
  );

  assign word_we = wr_en_i & in_range & ~hit_key & unlocked;
  assign err_d   = wr_en_i & (~in_range | (~hit_key & ~unlocked));

  prb_words #(.NUM_REGS(NUM_REGS), .IDX_W(IDX_W), .RST_BASE(RST_BASE)) u_words (
    .clk_i(clk_i), .rst_ni(rst_ni), .we_i(word_we), .wr_idx_i(idx),
    .wdata_i(wdata_i), .rd_idx_i(idx), .rd_word_o(rd_word)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      err_o   <= 1'b0;
      rdata_o <= '0;
    end else begin
      err_o <= err_d;
      if (rd_en_i) begin
        if (!in_range)    rdata_o <= '0;
        else if (hit_pri) rdata_o <= {31'b0, key_pri};
        else if (hit_sec) rdata_o <= {31'b0, key_sec};
        else              rdata_o <= rd_word;
      end
    end
  end

  initial assert (NUM_REGS > prb_pkg::SEC_KEY_IDX && NUM_REGS <= (1 << IDX_W));

  assert_lock_drop_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && in_range && !hit_pri && !hit_sec && !(key_pri && key_sec)) |=> err_o);
  assert_open_write_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && in_range && key_pri && key_sec) |=> !err_o);
  assert_range_err_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !in_range) |=> err_o);
  assert_err_cause_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> $past(wr_en_i));
  assert_key_read_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && !wr_en_i && hit_pri) |=> rdata_o == {31'b0, $past(key_pri)});
endmodule

// File: tb/prot_regbank_test.sv
`timescale 1ns/100ps
module prot_regbank_test;
  localparam int unsigned ADDR_W = 8;
  localparam int unsigned NREG   = 16;
  localparam logic [31:0] KEY    = 32'h1688A8A8;
  localparam logic [31:0] BASE   = 32'hA5A5_0000;

  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_en = 1'b0, rd_en = 1'b0;
  logic [ADDR_W-1:0] off = '0;
  logic [31:0] wdata = '0, rdata;
  logic err;

  always #2.5 clk = ~clk;

  prot_regbank #(.ADDR_W(ADDR_W), .NUM_REGS(NREG)) uut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .rd_en_i(rd_en),
    .offset_i(off), .wdata_i(wdata), .rdata_o(rdata), .err_o(err)
  );

  typedef struct { logic [31:0] val; string tag; } exp_t;
  exp_t rd_q[$];
  exp_t wr_q[$];
  int checks = 0, errors = 0;
  logic rd_seen = 1'b0, wr_seen = 1'b0;
  logic [31:0] model [NREG];
  logic k_pri = 1'b0, k_sec = 1'b0;

  always @(posedge clk) begin
    rd_seen <= rd_en;
    wr_seen <= wr_en;
  end

  // monitor
  always @(negedge clk) if (rst_n) begin
    exp_t e;
    if (rd_seen) begin
      e = rd_q.pop_front();
      checks++;
      if (rdata !== e.val) begin
        errors++;
        $display("FAIL %s read: actual %h expected %h", e.tag, rdata, e.val);
      end
    end
    if (wr_seen) begin
      e = wr_q.pop_front();
      checks++;
      if (err !== e.val[0]) begin
        errors++;
        $display("FAIL %s err: actual %b expected %b", e.tag, err, e.val[0]);
      end
    end else begin
      checks++;
      if (err !== 1'b0) begin
        errors++;
        $display("FAIL R8 err without write: actual %b expected 0", err);
      end
    end
  end

  task automatic do_wr(input logic [ADDR_W-1:0] o, input logic [31:0] d, input string tag);
    int idx = int'(o >> 2);
    logic e = 1'b0;
    if (idx >= NREG) e = 1'b1;
    else if (idx == 0) begin k_pri = (d == KEY); k_sec = (d == KEY); end
    else if (idx == 4) k_sec = (d == KEY);
    else if (!(k_pri && k_sec)) e = 1'b1;
    else model[idx] = d;
    wr_q.push_back('{val: {31'b0, e}, tag: tag});
    off = o; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic do_rd(input logic [ADDR_W-1:0] o, input string tag);
    int idx = int'(o >> 2);
    logic [31:0] v;
    if (idx >= NREG) v = '0;
    else if (idx == 0) v = {31'b0, k_pri};
    else if (idx == 4) v = {31'b0, k_sec};
    else v = model[idx];
    rd_q.push_back('{val: v, tag: tag});
    off = o; rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  initial begin
    #20000;
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < NREG; i++) model[i] = BASE + 32'(i);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    do_rd(8'h00, "R1");
    do_rd(8'h10, "R1");
    do_rd(8'h04, "R1");
    do_rd(8'h3C, "R1");
    // R4 locked write dropped
    do_wr(8'h08, 32'h1111_2222, "R4");
    do_rd(8'h08, "R4");
    // R9 near-miss key
    do_wr(8'h00, KEY ^ 32'h0000_0100, "R9");
    do_rd(8'h00, "R9");
    // R2 unlock, then key reads
    do_wr(8'h00, KEY, "R2");
    do_rd(8'h00, "R2");
    do_rd(8'h10, "R2");
    // R5 writes while open, back-to-back
    do_wr(8'h08, 32'hDEAD_BEEF, "R5");
    do_wr(8'h3C, 32'h0123_4567, "R5");
    do_wr(8'h0D, 32'hCAFE_F00D, "R5");   // low bits ignored, index 3
    do_rd(8'h08, "R5");
    do_rd(8'h3C, "R5");
    do_rd(8'h0C, "R5");
    // R6 out of range while open
    do_wr(8'h40, 32'hFFFF_FFFF, "R6");
    do_wr(8'hFC, 32'h0, "R6");
    do_rd(8'h40, "R7");
    do_rd(8'h3C, "R6");
    // R3 secondary relock, primary unchanged
    do_wr(8'h10, 32'h0, "R3");
    do_rd(8'h00, "R3");
    do_rd(8'h10, "R3");
    do_wr(8'h08, 32'h5555_AAAA, "R4");
    do_rd(8'h08, "R7");                   // reads work while locked
    // R3 secondary re-arm alone
    do_wr(8'h10, KEY, "R3");
    do_wr(8'h14, 32'h7777_0000, "R5");
    do_rd(8'h14, "R5");
    // R2 primary clears both
    do_wr(8'h00, 32'h0, "R2");
    do_rd(8'h10, "R2");
    do_wr(8'h14, 32'h8888_0000, "R4");
    do_rd(8'h14, "R4");
    // R6 out of range while locked
    do_wr(8'h80, 32'h1, "R6");
    repeat (3) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule